// File: doc/BRIEF.md
# Streaming Paired-Bayer Defect Pixel Corrector

This block cleans isolated bad pixels out of a raw 10-bit sensor stream before colour interpolation. The mosaic is arranged in row pairs: the two rows of a pair share one colour sequence, and the colour sequence alternates from one pair to the next. Every same-colour neighbour of a pixel therefore sits two columns away on the same row, on the other row of its own pair, or four rows away. The block keeps eight lines of raw history. It judges each pixel against five same-colour neighbours: left, right, pair partner, four rows up and four rows down.

A pixel is replaced only when it stands clear of every one of those neighbours by more than a programmable threshold, either above all of them or below all of them. The replacement value is the median of the five neighbours. Pixels in a four-pixel frame around the image are passed through untouched. The output stream has the same valid and line-start pattern as the input, two clock cycles later. The picture lags four lines, so the output for the pixel arriving at row r, column c is the result for row r-4, column c. A per-frame counter of replaced pixels is provided for checking.

Top module: `bayer_defect_fix`

## Requirements
- R1: A pixel in row 0..3, in the last four rows of a frame, in column 0..3, or in column width-4..width-1 is output unchanged, whatever its value.
- R2: An interior pixel whose value exceeds every one of its five neighbours plus the threshold is replaced.
- R3: An interior pixel whose value plus the threshold is below every one of its five neighbours is replaced.
- R4: An interior pixel that does not meet the condition of R2 or R3 is output unchanged. This includes the case where the difference to some neighbour is exactly the threshold.
- R5: The five neighbours of (r,c) are (r,c-2), (r,c+2), the pair partner at column c, (r-4,c) and (r+4,c). Decisions use uncorrected input values. A replaced pixel takes the median of the five neighbours.
- R6: The pair partner of an even row r is row r+1, and that of an odd row r is row r-1. Row parity is counted from the frame start.
- R7: vld_out and sol_out repeat vld_in and the line start of the input (sol_in or sof_in) exactly two cycles later. The sample output with the input pixel (r,c) is the result for (r-4,c).
- R8: During the first four lines after a frame start, the output carries the last four rows of the previous frame unchanged. After reset these rows read as zero.
- R9: defect_cnt counts replaced pixels, saturating at its maximum. It returns to zero on the cycle after a valid pixel with sof_in.
- R10: During reset all outputs are zero.
- R11: Idle cycles (vld_in low) anywhere in a frame change no result. Only the output timing shifts with them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_in | input | 10 | Raw input sample |
| vld_in | input | 1 | Input sample valid |
| sol_in | input | 1 | First sample of a line (qualified by vld_in) |
| sof_in | input | 1 | First sample of a frame; also starts a line |
| width_i | input | 7 | Active columns per line |
| thresh_i | input | 10 | Detection threshold |
| pix_out | output | 10 | Corrected sample, four lines behind |
| vld_out | output | 1 | Output sample valid |
| sol_out | output | 1 | Output line start |
| defect_cnt | output | 16 | Replaced pixels since the last frame start |

## Verification
On every accepted sample, the line store is read for the pixel four lines above the centre row. In the same cycle, the incoming sample is written to that very slot and column. A wrong ordering would swap the up neighbour for the new pixel. The bench provokes this with patches whose up and down neighbours differ, so that the detection decision or the median changes if the wrong value is used. Each output is compared against a model built from the neighbour rules. The frame-start counter clear also falls on the cycle when the previous frame's final outputs leave the pipeline. This is judged by reading the count one cycle after every frame start.

// File: rtl/bayer_defect_fix.sv
module bayer_defect_fix #(
  parameter int DW    = 10,
  parameter int MAX_W = 64,
  parameter int EDGE  = 4,
  parameter int CNTW  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DW-1:0]     pix_in,
  input  logic              vld_in,
  input  logic              sol_in,
  input  logic              sof_in,
  input  logic [$clog2(MAX_W):0] width_i,
  input  logic [DW-1:0]     thresh_i,
  output logic [DW-1:0]     pix_out,
  output logic              vld_out,
  output logic              sol_out,
  output logic [CNTW-1:0]   defect_cnt
);
  localparam int COLW  = $clog2(MAX_W);
  localparam int VOFF  = 4;
  localparam int SLOTS = 2 * VOFF;
  localparam int SW    = $clog2(SLOTS);
  localparam int RLIM  = VOFF + EDGE;
  localparam int RW    = $clog2(RLIM + 1);
  localparam int NB    = 5;

  logic [DW-1:0] lbuf [SLOTS*MAX_W];

  logic [COLW-1:0] col_q, col_n;
  logic [SW-1:0]   slot_q, slot_n, cs, ps;
  logic [RW-1:0]   row_q, row_n;
  logic            par_q, par_n, ls, bord;

  assign ls     = sol_in | sof_in;
  assign col_n  = ls ? '0 : col_q + 1'b1;
  assign slot_n = ls ? slot_q + 1'b1 : slot_q;
  assign row_n  = sof_in ? '0 : (!ls || row_q == RW'(RLIM)) ? row_q : row_q + 1'b1;
  assign par_n  = sof_in ? 1'b0 : (ls ? ~par_q : par_q);
  assign cs     = slot_n - SW'(VOFF);
  assign ps     = par_n ? slot_n - SW'(VOFF + 1) : slot_n - SW'(VOFF - 1);
  assign bord   = (row_n < RW'(RLIM)) || (col_n < COLW'(EDGE)) ||
                  ({1'b0, col_n} + (COLW+1)'(EDGE) >= width_i);

  logic            s1_vld, s1_sol, s1_bord;
  logic [DW-1:0]   s1_c;
  logic [DW-1:0]   s1_nb [NB];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < SLOTS*MAX_W; i++) lbuf[i] <= '0;
    end else if (vld_in) begin
      lbuf[{slot_n, col_n}] <= pix_in;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      col_q   <= '0;
      slot_q  <= '1;
      row_q   <= '0;
      par_q   <= 1'b1;
      s1_vld  <= 1'b0;
      s1_sol  <= 1'b0;
      s1_bord <= 1'b1;
      s1_c    <= '0;
      for (int i = 0; i < NB; i++) s1_nb[i] <= '0;
    end else begin
      s1_vld <= vld_in;
      s1_sol <= vld_in & ls;
      if (vld_in) begin
        col_q    <= col_n;
        slot_q   <= slot_n;
        row_q    <= row_n;
        par_q    <= par_n;
        s1_bord  <= bord;
        s1_c     <= lbuf[{cs, col_n}];
        s1_nb[0] <= lbuf[{cs, col_n - COLW'(2)}];
        s1_nb[1] <= lbuf[{cs, col_n + COLW'(2)}];
        s1_nb[2] <= lbuf[{ps, col_n}];
        s1_nb[3] <= lbuf[{slot_n, col_n}];
        s1_nb[4] <= pix_in;
      end
    end
  end

  logic          hi_all, lo_all, fix;
  logic [2:0]    rank [NB];
  logic [DW-1:0] med;

  always_comb begin
    hi_all = 1'b1;
    lo_all = 1'b1;
    for (int i = 0; i < NB; i++) begin
      if ({1'b0, s1_c} <= {1'b0, s1_nb[i]} + {1'b0, thresh_i}) hi_all = 1'b0;
      if ({1'b0, s1_c} + {1'b0, thresh_i} >= {1'b0, s1_nb[i]}) lo_all = 1'b0;
    end
  end

  always_comb begin
    med = s1_nb[0];
    for (int i = 0; i < NB; i++) begin
      rank[i] = '0;
      for (int j = 0; j < NB; j++)
        if (j != i && (s1_nb[j] < s1_nb[i] || (s1_nb[j] == s1_nb[i] && j < i)))
          rank[i] = rank[i] + 3'd1;
    end
    for (int i = 0; i < NB; i++)
      if (rank[i] == 3'd2) med = s1_nb[i];
  end

  assign fix = s1_vld & ~s1_bord & (hi_all | lo_all);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_out    <= 1'b0;
      sol_out    <= 1'b0;
      pix_out    <= '0;
      defect_cnt <= '0;
    end else begin
      vld_out <= s1_vld;
      sol_out <= s1_sol;
      if (s1_vld) pix_out <= fix ? med : s1_c;
      if (vld_in && sof_in)            defect_cnt <= '0;
      else if (fix && defect_cnt != '1) defect_cnt <= defect_cnt + 1'b1;
    end
  end

  logic [1:0] age;
  always_ff @(posedge clk) begin
    if (!rst_n)        age <= '0;
    else if (!age[1])  age <= age + 1'b1;
  end

  p_lat_vld_r7: assert property (@(posedge clk) disable iff (!rst_n)
    age[1] |-> vld_out == $past(vld_in, 2));

  p_sol_vld_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sol_out |-> vld_out);

  p_cnt_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_in && sof_in) |=> defect_cnt == '0);

  p_cnt_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(vld_in && sof_in) |=> (defect_cnt == $past(defect_cnt) ||
                             defect_cnt == $past(defect_cnt) + 1'b1));

  p_border_pass_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_vld && s1_bord) |=> pix_out == $past(s1_c));

endmodule

// File: tb/bayer_defect_fix_bench.sv
`timescale 1ns/1ps
module bayer_defect_fix_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [9:0] pix_in = '0;
  logic vld_in = 1'b0, sol_in = 1'b0, sof_in = 1'b0;
  logic [6:0] width_i = 7'd16;
  logic [9:0] thresh_i = '0;
  logic [9:0] pix_out;
  logic vld_out, sol_out;
  logic [15:0] defect_cnt;

  always #2 clk = ~clk;

  bayer_defect_fix u_bayer_defect_fix (
    .clk(clk), .rst_n(rst_n), .pix_in(pix_in), .vld_in(vld_in),
    .sol_in(sol_in), .sof_in(sof_in), .width_i(width_i), .thresh_i(thresh_i),
    .pix_out(pix_out), .vld_out(vld_out), .sol_out(sol_out),
    .defect_cnt(defect_cnt));

  // row, thr, centre, left, right, partner, up, down, expected centre output
  localparam int NV = 10;
  localparam int TV [NV][9] = '{
    '{6, 50,  500, 100, 110, 120, 130, 140, 120},
    '{7, 50,   10, 200, 210, 220, 230, 240, 220},
    '{6, 50,  500, 100, 110, 600, 130, 140, 500},
    '{7, 50,  300, 200, 210, 220, 230, 250, 300},
    '{6, 50,  301, 200, 210, 220, 230, 250, 220},
    '{7,  0,  101, 100, 100, 100, 100, 100, 100},
    '{6, 1023, 1023,  0,   0,   0,   0,   0, 1023},
    '{7, 49,    0,  50,  60,  70,  80,  90,  70},
    '{6, 50,    0,  50,  60,  70,  80,  90,   0},
    '{7, 10,  400,  90, 300,  95, 350, 100, 100}
  };

  int img [32][64];
  int prv [32][64];
  int fh, fw, fthr, prev_h, prev_w;
  bit prev_any, key_on, pend_clr;
  int krow, kexp;
  string ktag, itag;
  int q_exp[$], q_sol[$], q_cyc[$], q_pos[$];
  string q_tag[$];
  int cyc = 0, checks = 0, fails = 0;

  always @(posedge clk) cyc++;

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic int ref_pix(int rc, int c, output bit fx);
    int nb [5];
    int t;
    bit hi, lo;
    fx = 0;
    if (rc < 4 || rc >= fh - 4 || c < 4 || c >= fw - 4) return img[rc][c];
    nb[0] = img[rc][c-2]; nb[1] = img[rc][c+2]; nb[2] = img[rc ^ 1][c];
    nb[3] = img[rc-4][c]; nb[4] = img[rc+4][c];
    hi = 1; lo = 1;
    for (int i = 0; i < 5; i++) begin
      if (!(img[rc][c] > nb[i] + fthr)) hi = 0;
      if (!(img[rc][c] + fthr < nb[i])) lo = 0;
    end
    if (!(hi || lo)) return img[rc][c];
    fx = 1;
    for (int i = 0; i < 5; i++)
      for (int j = 0; j < 4 - i; j++)
        if (nb[j] > nb[j+1]) begin t = nb[j]; nb[j] = nb[j+1]; nb[j+1] = t; end
    return nb[2];
  endfunction

  always @(negedge clk) begin
    if (rst_n && vld_out) begin
      if (q_exp.size() == 0) chk(0, "R7", "output valid with nothing pending", 1, 0);
      else begin
        int e, s, cy, p;
        string tg;
        e = q_exp.pop_front(); s = q_sol.pop_front(); cy = q_cyc.pop_front();
        p = q_pos.pop_front(); tg = q_tag.pop_front();
        if (e >= 0) chk(pix_out == e, tg, $sformatf("pixel row %0d col %0d", p / 64, p % 64), pix_out, e);
        chk(sol_out == s, "R7", "line start alignment", sol_out, s);
        chk(cyc - cy == 2, "R7", "output latency", cyc - cy, 2);
      end
    end else if (rst_n && q_cyc.size() > 0 && cyc - q_cyc[0] >= 2) begin
      chk(0, "R7", "missing output valid", 0, 1);
      void'(q_exp.pop_front()); void'(q_sol.pop_front()); void'(q_cyc.pop_front());
      void'(q_pos.pop_front()); void'(q_tag.pop_front());
    end
  end

  task automatic fill(int bg);
    for (int r = 0; r < 32; r++) for (int c = 0; c < 64; c++) img[r][c] = bg;
  endtask

  task automatic idle_edge();
    @(negedge clk);
    if (pend_clr) begin
      chk(defect_cnt == 0, "R9", "count cleared after frame start", defect_cnt, 0);
      pend_clr = 0;
    end
  endtask

  task automatic send_frame(int h, int w, int thr, bit gaps);
    int ecnt, e;
    bit fx, prev_ok;
    string tg;
    fh = h; fw = w; fthr = thr;
    ecnt = 0;
    for (int r = 4; r < h - 4; r++)
      for (int c = 4; c < w - 4; c++) begin
        void'(ref_pix(r, c, fx));
        if (fx) ecnt++;
      end
    prev_ok = prev_any || prev_w == w;
    for (int r = 0; r < h; r++)
      for (int c = 0; c < w; c++) begin
        if (gaps && ((r * 5 + c * 3) % 7 == 0)) begin
          idle_edge();
          vld_in = 0; sol_in = 0; sof_in = 0;
        end
        idle_edge();
        vld_in = 1; pix_in = 10'(img[r][c]);
        sol_in = (c == 0); sof_in = (r == 0 && c == 0);
        if (r == 0 && c == 0) begin width_i = 7'(w); thresh_i = 10'(thr); end
        if (r >= 4) begin
          e = ref_pix(r - 4, c, fx);
          tg = (r - 4 < 4 || r - 4 >= h - 4 || c < 4 || c >= w - 4) ? "R1" : itag;
          if (key_on && r - 4 == krow && c == 6) begin e = kexp; tg = ktag; end
        end else begin
          e = prev_ok ? prv[prev_h - 4 + r][c] : -1;
          tg = "R8";
        end
        q_exp.push_back(e); q_sol.push_back(c == 0); q_cyc.push_back(cyc);
        q_pos.push_back(((r + 32 - 4) % 32) * 64 + c); q_tag.push_back(tg);
        if (r == 0 && c == 0) pend_clr = 1;
      end
    idle_edge();
    vld_in = 0; sol_in = 0; sof_in = 0;
    repeat (3) @(negedge clk);
    chk(defect_cnt == ecnt, "R9", "replaced pixels in frame", defect_cnt, ecnt);
    for (int r = 0; r < 32; r++) for (int c = 0; c < 64; c++) prv[r][c] = img[r][c];
    prev_h = h; prev_w = w; prev_any = 0;
  endtask

  task automatic reset_check();
    chk(pix_out == 0, "R10", "pix_out in reset", pix_out, 0);
    chk(vld_out == 0, "R10", "vld_out in reset", vld_out, 0);
    chk(sol_out == 0, "R10", "sol_out in reset", sol_out, 0);
    chk(defect_cnt == 0, "R10", "defect_cnt in reset", defect_cnt, 0);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R7 watchdog expired");
    summary();
    $finish;
  end

  initial begin
    itag = "R5";
    key_on = 0; pend_clr = 0;
    for (int r = 0; r < 32; r++) for (int c = 0; c < 64; c++) prv[r][c] = 0;
    prev_any = 1; prev_h = 8; prev_w = 16;
    repeat (3) @(negedge clk);
    reset_check();
    rst_n = 1;

    // table of neighbourhood patches, one frame each (R2 R3 R4 R5 R6)
    for (int e = 0; e < NV; e++) begin
      int rr;
      rr = TV[e][0];
      fill(100);
      img[rr][6] = TV[e][2]; img[rr][4] = TV[e][3]; img[rr][8] = TV[e][4];
      img[rr ^ 1][6] = TV[e][5]; img[rr - 4][6] = TV[e][6]; img[rr + 4][6] = TV[e][7];
      kexp = TV[e][8]; krow = rr; key_on = 1;
      ktag = (kexp == TV[e][2]) ? "R4" : (TV[e][2] > kexp ? "R2" : "R3");
      if (rr % 2 == 1) ktag = {ktag, "/R6"};
      send_frame(16, 16, TV[e][1], 0);
      key_on = 0;
    end

    // border exclusion with idle gaps (R1 R11)
    itag = "R11";
    fill(100);
    img[2][6] = 900; img[6][2] = 900; img[6][12] = 900; img[12][6] = 900;
    img[13][13] = 900; img[3][3] = 900; img[6][11] = 900;
    send_frame(16, 16, 50, 1);

    // wider lines, frame height not a multiple of eight (R5 R8)
    itag = "R5";
    fill(0);
    for (int r = 0; r < 13; r++) for (int c = 0; c < 20; c++)
      img[r][c] = (r * 37 + c * 11) % 256 + (((r * 3 + c) % 9 == 0) ? 700 : 0);
    send_frame(13, 20, 30, 0);
    itag = "R11";
    fill(0);
    for (int r = 0; r < 16; r++) for (int c = 0; c < 20; c++)
      img[r][c] = ((r * 131 + c * 71) * 13) % 1024;
    send_frame(16, 20, 200, 1);

    // reset in the middle of operation clears history (R10 R8)
    itag = "R5";
    @(negedge clk); rst_n = 0;
    repeat (2) @(negedge clk);
    reset_check();
    rst_n = 1;
    for (int r = 0; r < 32; r++) for (int c = 0; c < 64; c++) prv[r][c] = 0;
    prev_any = 1;
    fill(100);
    img[7][9] = 0;
    send_frame(16, 16, 20, 0);
    fill(50);
    send_frame(16, 16, 50, 0);

    repeat (4) @(negedge clk);
    chk(q_exp.size() == 0, "R7", "outputs still pending at end", q_exp.size(), 0);
    summary();
    $finish;
  end
endmodule